// File: doc/BRIEF.md
# Bus Latency Timeout Watchdog

This block measures how long a bus master request goes without a grant. When the wait reaches a programmed limit, it raises a master-error flag. The limit is a 16-bit count of time ticks. A prescaler makes one tick every `TICK_DIV` bus clocks, and it runs only while a request is waiting. A limit of zero turns the watchdog off. The error flag is sticky and drives an interrupt request. That request can be masked, and it also needs a global enable.

Software reaches the block through a small write and read port with two addresses:

- **Address 0 is the limit.** It can be written and read back only while the controller is stopped or suspended. At other times a write has no effect and a read returns zero.
- **Address 1 is the status word.** Bit 0 holds the error flag. Writing 1 to bit 0 clears the flag.

A hard reset (`rst_n` low) or a soft reset (`sw_rst` high for one clock) loads the limit with 1536 and clears the flag.

The controller has three states:

- **IDLE:** no request is waiting.
- **WAIT:** a request is waiting and the tick counter runs.
- **EXPIRED:** the limit has been reached.

It moves between them as follows:

| From | Condition | To |
|------|-----------|----|
| IDLE | request without grant | WAIT |
| WAIT | grant, or the request drops | IDLE |
| WAIT | tick on which the count reaches the limit | EXPIRED |
| EXPIRED | grant, or the request drops | IDLE |
| any state | soft reset | IDLE |

Top module: `bus_lat_watchdog`

## Requirements
- R1: After a hard reset, the limit reads 0x0600, `merr` is 0 and `irq` is 0.
- R2: A write to address 0 updates the limit only when `stop_bit` or `suspend_bit` is 1. Otherwise the write is ignored.
- R3: A read of address 0 returns the limit while `stop_bit` or `suspend_bit` is 1, and 0x0000 otherwise. A read of address 1 returns `merr` in bit 0 and zeros in the other bits.
- R4: Raising and then dropping `stop_bit` leaves the limit unchanged.
- R5: With a nonzero limit L, take edge E as the first clock edge that samples `bus_req`=1 and `bus_gnt`=0 in IDLE. If the request stays ungranted, `merr` becomes 1 at edge E+L*TICK_DIV and is 0 one edge before that.
- R6: With a limit of 0, `merr` never becomes 1, however long the request waits.
- R7: A grant, or a dropped request, returns the block to IDLE and clears both the prescaler and the tick count. A later request therefore times at the full R5 delay.
- R8: `merr` stays 1 until software writes a 1 to bit 0 of address 1. Writing a 0 there has no effect. A status write is accepted whatever `stop_bit` and `suspend_bit` are.
- R9: `irq` is 1 exactly when `merr` is 1, `mask_bit` is 0 and `int_en` is 1.
- R10: A one-cycle `sw_rst` pulse loads the limit with 0x0600, clears `merr` and returns the block to IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| sw_rst | input | 1 | Synchronous soft reset |
| stop_bit | input | 1 | Controller stopped; opens the limit register |
| suspend_bit | input | 1 | Controller suspended; opens the limit register |
| mask_bit | input | 1 | Masks the master-error interrupt when 1 |
| int_en | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 is the limit, 1 is the status word |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| bus_req | input | 1 | Bus master request pending |
| bus_gnt | input | 1 | Bus grant |
| merr | output | 1 | Sticky master-error status |
| irq | output | 1 | Interrupt request |

## Verification
The bench samples `merr` one edge before and exactly at the expected expiry, so a prescaler or counter that is off by one is caught. It checks a grant in mid-wait followed by a new request. A design that failed to clear the count would expire early on that second request. It holds a zero limit for a long wait, which catches a design that compares against zero and fires on the first tick. It also tries limit writes with both gate bits low and checks that a pulse on `stop_bit` leaves the limit intact. Further checks cover clearing `merr` by writing 0 and by writing 1, each combination of mask and enable for `irq`, and a soft reset that restores 0x0600.

// File: rtl/bus_lat_pkg.sv
package bus_lat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT    = 2'd1,
        ST_EXPIRED = 2'd2
    } lat_state_e;

    localparam logic ADDR_LIMIT  = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;

endpackage

// File: rtl/bus_lat_prescale.sv
module bus_lat_prescale #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic run,
    output logic tick
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    generate
        if (TICK_DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            logic [PRE_W-1:0] pre_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (sw_rst || !run) begin
                    pre_q <= '0;
                end else if (pre_q == PRE_LAST) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign tick = run && (pre_q == PRE_LAST);
        end
    endgenerate

endmodule

// File: rtl/bus_lat_fsm.sv
module bus_lat_fsm
    import bus_lat_pkg::*;
#(
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             bus_req,
    input  logic             bus_gnt,
    input  logic             tick,
    input  logic [LIM_W-1:0] limit,
    output logic             run,
    output logic             timeout_evt,
    output lat_state_e       state_o
);
    localparam logic [LIM_W-1:0] CNT_MAX = '1;

    lat_state_e       state_q, state_d;
    logic [LIM_W-1:0] lat_q;
    logic             waiting;
    logic             reached;

    assign waiting = bus_req && !bus_gnt;
    assign reached = tick && (limit != '0) &&
                     (({1'b0, lat_q} + 1'b1) >= {1'b0, limit});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (sw_rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (waiting) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!waiting)     state_d = ST_IDLE;
                else if (reached) state_d = ST_EXPIRED;
            end
            ST_EXPIRED: begin
                if (!waiting) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        run         = 1'b0;
        timeout_evt = 1'b0;
        unique case (state_q)
            ST_IDLE:    run = 1'b0;
            ST_WAIT: begin
                run         = waiting;
                timeout_evt = waiting && reached;
            end
            ST_EXPIRED: run = 1'b0;
            default:    run = 1'b0;
        endcase
    end

    // Saturating latency tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (sw_rst || !run) begin
            lat_q <= '0;
        end else if (tick && (lat_q != CNT_MAX)) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/bus_lat_regs.sv
module bus_lat_regs
    import bus_lat_pkg::*;
#(
    parameter int              LIM_W   = 16,
    parameter logic [LIM_W-1:0] LIM_RST = 16'h0600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             cfg_open,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [LIM_W-1:0] reg_wdata,
    input  logic             timeout_evt,
    output logic [LIM_W-1:0] limit_q,
    output logic             merr_q,
    output logic [LIM_W-1:0] reg_rdata
);
    logic lim_we;
    logic merr_clr;

    assign lim_we   = reg_wr && (reg_addr == ADDR_LIMIT) && cfg_open;
    assign merr_clr = reg_wr && (reg_addr == ADDR_STATUS) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= LIM_RST;
        end else if (sw_rst) begin
            limit_q <= LIM_RST;
        end else if (lim_we) begin
            limit_q <= reg_wdata;
        end
    end

    // Sticky flag: a new timeout wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            merr_q <= 1'b0;
        end else if (sw_rst) begin
            merr_q <= 1'b0;
        end else if (timeout_evt) begin
            merr_q <= 1'b1;
        end else if (merr_clr) begin
            merr_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_LIMIT) begin
            if (cfg_open) reg_rdata = limit_q;
        end else begin
            reg_rdata[0] = merr_q;
        end
    end

endmodule

// File: rtl/bus_lat_watchdog.sv
module bus_lat_watchdog
    import bus_lat_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_rst,
    input  logic        stop_bit,
    input  logic        suspend_bit,
    input  logic        mask_bit,
    input  logic        int_en,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        bus_req,
    input  logic        bus_gnt,
    output logic        merr,
    output logic        irq
);
    localparam int LIM_W = 16;
    localparam logic [LIM_W-1:0] LIM_RST = 16'h0600;

    logic             run;
    logic             tick;
    logic             timeout_evt;
    logic [LIM_W-1:0] lim_q;
    lat_state_e       fsm_state;

    bus_lat_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_rst (sw_rst),
        .run    (run),
        .tick   (tick)
    );

    bus_lat_fsm #(.LIM_W(LIM_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_rst      (sw_rst),
        .bus_req     (bus_req),
        .bus_gnt     (bus_gnt),
        .tick        (tick),
        .limit       (lim_q),
        .run         (run),
        .timeout_evt (timeout_evt),
        .state_o     (fsm_state)
    );

    bus_lat_regs #(.LIM_W(LIM_W), .LIM_RST(LIM_RST)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_rst      (sw_rst),
        .cfg_open    (stop_bit || suspend_bit),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .timeout_evt (timeout_evt),
        .limit_q     (lim_q),
        .merr_q      (merr),
        .reg_rdata   (reg_rdata)
    );

    assign irq = merr && !mask_bit && int_en;

endmodule

// File: rtl/bus_lat_checker.sv
module bus_lat_checker
    import bus_lat_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        sw_rst,
    input logic        stop_bit,
    input logic        suspend_bit,
    input logic        mask_bit,
    input logic        int_en,
    input logic        reg_wr,
    input logic        reg_addr,
    input logic [15:0] reg_wdata,
    input logic        bus_req,
    input logic        bus_gnt,
    input logic        merr,
    input logic        irq,
    input logic [15:0] limit,
    input lat_state_e  state
);
    p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (limit == 16'h0600) && !merr && (state == ST_IDLE));

    p_limit_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_bit && !suspend_bit && !sw_rst) |=> $stable(limit));

    p_zero_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((limit == 16'h0000) && !merr) |=> !merr);

    p_merr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (merr && !sw_rst && !(reg_wr && reg_addr && reg_wdata[0])) |=> merr);

    p_release_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req || bus_gnt) |=> (state == ST_IDLE));

    p_expire_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_EXPIRED) |-> merr);

    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_bit || !int_en) |-> !irq);

endmodule

bind bus_lat_watchdog bus_lat_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_rst      (sw_rst),
    .stop_bit    (stop_bit),
    .suspend_bit (suspend_bit),
    .mask_bit    (mask_bit),
    .int_en      (int_en),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .merr        (merr),
    .irq         (irq),
    .limit       (lim_q),
    .state       (fsm_state)
);

// File: tb/bus_lat_watchdog_bench.sv
`timescale 1ns/1ps
module bus_lat_watchdog_bench;
    localparam int DIV = 4;
    localparam int K_MERR = 0;
    localparam int K_IRQ  = 1;
    localparam int K_RD   = 2;

    typedef struct {
        int          cyc;
        int          kind;
        logic [15:0] exp;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        stop_bit = 1'b0;
    logic        suspend_bit = 1'b0;
    logic        mask_bit = 1'b0;
    logic        int_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        bus_req = 1'b0;
    logic        bus_gnt = 1'b0;
    logic        merr;
    logic        irq;

    int        cyc = 0;
    int        n_cmp = 0;
    int        n_bad = 0;
    bit        done = 1'b0;
    exp_item_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bus_lat_watchdog #(.TICK_DIV(DIV)) u_bus_lat_watchdog (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .stop_bit(stop_bit),
        .suspend_bit(suspend_bit), .mask_bit(mask_bit), .int_en(int_en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .merr(merr), .irq(irq)
    );

    task automatic expect_at(int c, int kind, logic [15:0] v, string tag);
        exp_item_t it;
        it.cyc = c; it.kind = kind; it.exp = v; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares queued expectations in their cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].cyc <= cyc) begin
                exp_item_t it;
                logic [15:0] act;
                it = sb.pop_front();
                case (it.kind)
                    K_MERR:  act = {15'b0, merr};
                    K_IRQ:   act = {15'b0, irq};
                    default: act = reg_rdata;
                endcase
                n_cmp++;
                if (it.cyc != cyc || act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d cyc=%0d/%0d actual=%h expected=%h",
                             it.tag, it.kind, cyc, it.cyc, act, it.exp);
                end
            end
        end
    end

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(logic a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            finish_up();
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        @(negedge clk);
        stop_bit = 1'b1;
        expect_at(cyc, K_RD, 16'h0600, "R1");
        expect_at(cyc, K_MERR, 16'h0, "R1");
        expect_at(cyc, K_IRQ, 16'h0, "R1");
        drain();

        // R3: read gated closed
        stop_bit = 1'b0;
        expect_at(cyc, K_RD, 16'h0000, "R3");
        drain();

        // R2: write ignored with both gates low
        reg_write(1'b0, 16'h0005);
        stop_bit = 1'b1;
        expect_at(cyc, K_RD, 16'h0600, "R2");
        drain();

        // R2: write accepted with suspend only
        stop_bit = 1'b0; suspend_bit = 1'b1;
        reg_write(1'b0, 16'h0003);
        expect_at(cyc, K_RD, 16'h0003, "R2");
        drain();
        suspend_bit = 1'b0;

        // R4: stop pulse keeps the limit
        @(negedge clk); stop_bit = 1'b1;
        @(negedge clk); stop_bit = 1'b0;
        @(negedge clk); suspend_bit = 1'b1;
        expect_at(cyc, K_RD, 16'h0003, "R4");
        drain();
        suspend_bit = 1'b0;

        // R5 / R9: timeout with limit 3
        int_en = 1'b1; mask_bit = 1'b0;
        @(negedge clk);
        bus_req = 1'b1;
        k = cyc;
        expect_at(k + 3*DIV, K_MERR, 16'h0, "R5");
        expect_at(k + 1 + 3*DIV, K_MERR, 16'h1, "R5");
        expect_at(k + 1 + 3*DIV, K_IRQ, 16'h1, "R9");
        drain();

        mask_bit = 1'b1;
        expect_at(cyc, K_IRQ, 16'h0, "R9");
        drain();
        mask_bit = 1'b0; int_en = 1'b0;
        expect_at(cyc, K_IRQ, 16'h0, "R9");
        drain();
        int_en = 1'b1;
        expect_at(cyc, K_IRQ, 16'h1, "R9");
        drain();

        // R8: sticky, write-0 ignored, write-1 clears
        bus_req = 1'b0;
        repeat (5) @(negedge clk);
        expect_at(cyc, K_MERR, 16'h1, "R8");
        drain();
        reg_write(1'b1, 16'h0000);
        expect_at(cyc, K_MERR, 16'h1, "R8");
        drain();
        reg_write(1'b1, 16'h0001);
        expect_at(cyc, K_MERR, 16'h0, "R8");
        drain();

        // R7: grant mid-wait restarts the count
        @(negedge clk);
        bus_req = 1'b1;
        repeat (2*DIV) @(negedge clk);
        bus_gnt = 1'b1;
        k = cyc;
        @(negedge clk);
        bus_gnt = 1'b0;
        expect_at(k + 1 + 3*DIV, K_MERR, 16'h0, "R7");
        expect_at(k + 2 + 3*DIV, K_MERR, 16'h1, "R7");
        drain();
        bus_req = 1'b0;
        reg_write(1'b1, 16'h0001);

        // R6: zero limit never times out
        suspend_bit = 1'b1;
        reg_write(1'b0, 16'h0000);
        suspend_bit = 1'b0;
        @(negedge clk);
        bus_req = 1'b1;
        repeat (60) @(negedge clk);
        expect_at(cyc, K_MERR, 16'h0, "R6");
        drain();
        repeat (60) @(negedge clk);
        expect_at(cyc, K_MERR, 16'h0, "R6");
        drain();
        bus_req = 1'b0;

        // R10: soft reset restores limit and clears the flag
        suspend_bit = 1'b1;
        reg_write(1'b0, 16'h0002);
        suspend_bit = 1'b0;
        @(negedge clk);
        bus_req = 1'b1;
        k = cyc;
        expect_at(k + 1 + 2*DIV, K_MERR, 16'h1, "R10");
        drain();
        bus_req = 1'b0;
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0; stop_bit = 1'b1;
        expect_at(cyc, K_MERR, 16'h0, "R10");
        expect_at(cyc, K_RD, 16'h0600, "R10");
        drain();
        stop_bit = 1'b0;

        done = 1'b1;
        finish_up();
    end

endmodule